// File: doc/BRIEF.md
# Streaming Gradient-Orientation Cell Histogram Extractor

This block turns a raster stream of 8-bit grayscale pixels into one orientation histogram for every 8x8 pixel cell of a frame. At each pixel it forms a centred horizontal and vertical difference and approximates the gradient strength as the sum of their absolute values. It folds the gradient direction into the half-circle and adds the strength into one of nine 20-degree bins of the cell that holds the pixel. A default 640x480 frame gives 80x60 cell records, each carrying its cell column, cell row and all nine bin totals.

Two line buffers hold the neighbourhood, and one accumulator per bin and per cell column holds the partial sums of the cell row in progress. A row is processed while the row below it streams in. The bottom row is processed in a drain pass of one line length after the last pixel, and input is held off during that pass. A stalled output holds off the input, so no pixel is lost or repeated.

Top module: `hog_cell_hist`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: For a pixel at column x and row y, gx is the pixel at x+1 minus the pixel at x-1 on the same row, and gy is the pixel at y+1 minus the pixel at y-1 in the same column (the lower row minus the upper row). Any neighbour outside the frame takes the value of the nearest edge pixel.
- R3: Each pixel adds |gx|+|gy| to exactly one bin of its cell and leaves the other eight bins unchanged. A frame with no gradient yields all-zero bins.
- R4: If gy<0, or gy=0 and gx<0, both components are negated. Then, with a=|gx| and Q8 constants 93, 215, 443 and 1452, the bin is the number of constants t with 256*gy >= t*a when gx>=0, and 8 minus the number with 256*gy > t*a when gx<0.
- R5: One record is produced per 8x8 cell, and bin k sits at `out_bins[k*BIN_W +: BIN_W]`.
- R6: Records come out in raster order of cells, exactly one per cell per frame. A cell's record is produced once the pixel in its bottom-right corner has been processed. The bottom cell row is completed in a drain pass during which `in_ready` stays low.
- R7: A bin total that would pass 2^BIN_W-1 holds at 2^BIN_W-1.
- R8: While `out_valid` is high and `out_ready` is low, the record stays unchanged and no input is taken. Under any pattern of `out_ready` and `in_valid`, the record sequence is the same as with no stalls.
- R9: A pixel marked `in_sof` is taken as column 0 of row 0, so stray pixels before it do not change the records. `in_eol` marks the last pixel of each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel taken when high together with in_valid |
| in_pix | input | PIX_W | Grayscale pixel value |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Cell record present |
| out_ready | input | 1 | Downstream takes the record |
| out_cell_x | output | CXW | Cell column of the record |
| out_cell_y | output | CYW | Cell row of the record |
| out_bins | output | 9*BIN_W | Nine bin totals, bin k in slice k |

## Verification
The assertions assume well-formed frames: `in_eol` on every IMG_W-th pixel, exactly IMG_H lines per frame, and `in_sof` only on the first pixel of a frame. The raster-order and drain checks count lines and cells on those assumptions. The stimulus always sends complete, correctly marked frames. Its only deviation is a few unmarked stray pixels placed before a start-of-frame marker, which never carry `in_eol`. Input gaps and random output stalls change only the timing and never the frame shape.

// File: rtl/hog_pkg.sv
`timescale 1ns/1ps
package hog_pkg;
  localparam int NBINS    = 9;
  localparam int NBOUND   = 4;
  localparam int TAN_FRAC = 8;

  // tangent of the bin boundaries at 20, 40, 60 and 80 degrees, Q8
  function automatic int tan_q8(input int k);
    case (k)
      0:       return 93;
      1:       return 215;
      2:       return 443;
      default: return 1452;
    endcase
  endfunction
endpackage

// File: rtl/hog_linebuf.sv
`timescale 1ns/1ps
module hog_linebuf #(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8,
  localparam int XW = $clog2(IMG_W)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             cur_sel,
  input  logic [XW-1:0]    pos_x,
  input  logic [PIX_W-1:0] wr_pix,
  output logic [PIX_W-1:0] cur_left,
  output logic [PIX_W-1:0] cur_right,
  output logic [PIX_W-1:0] cur_mid,
  output logic [PIX_W-1:0] oth_mid
);
  logic [XW-1:0] xm, xp;
  logic [PIX_W-1:0] rd_l [2];
  logic [PIX_W-1:0] rd_r [2];
  logic [PIX_W-1:0] rd_m [2];

  assign xm = (pos_x == '0) ? pos_x : pos_x - 1'b1;
  assign xp = (int'(pos_x) == IMG_W - 1) ? pos_x : pos_x + 1'b1;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] row [IMG_W];
    logic             we;
    assign we = wr_en && (cur_sel != b[0]);
    always_ff @(posedge clk) begin
      if (we) row[pos_x] <= wr_pix;
    end
    assign rd_l[b] = row[xm];
    assign rd_r[b] = row[xp];
    assign rd_m[b] = row[pos_x];
  end

  assign cur_left  = rd_l[cur_sel];
  assign cur_right = rd_r[cur_sel];
  assign cur_mid   = rd_m[cur_sel];
  assign oth_mid   = rd_m[~cur_sel];
endmodule

// File: rtl/hog_gradbin.sv
`timescale 1ns/1ps
module hog_gradbin
  import hog_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int MAG_W = PIX_W + 1,
  localparam int BNW = $clog2(NBINS),
  localparam int PROD_W = PIX_W + 12
) (
  input  logic [PIX_W-1:0] left,
  input  logic [PIX_W-1:0] right,
  input  logic [PIX_W-1:0] up,
  input  logic [PIX_W-1:0] down,
  output logic [MAG_W-1:0] mag,
  output logic [BNW-1:0]   bin
);
  logic signed [PIX_W:0] gx, gy, fx, fy;
  logic                  flip;
  logic [PIX_W-1:0]      ax, ay;
  logic [PROD_W-1:0]     lhs;
  logic [NBOUND-1:0]     ge, gt;

  assign gx   = $signed({1'b0, right}) - $signed({1'b0, left});
  assign gy   = $signed({1'b0, down}) - $signed({1'b0, up});
  assign flip = gy[PIX_W] | ((gy == '0) & gx[PIX_W]);
  assign fx   = flip ? -gx : gx;
  assign fy   = flip ? -gy : gy;
  assign ax   = fx[PIX_W] ? PIX_W'(-fx) : fx[PIX_W-1:0];
  assign ay   = fy[PIX_W-1:0];
  assign mag  = {1'b0, ax} + {1'b0, ay};
  assign lhs  = PROD_W'({ay, {TAN_FRAC{1'b0}}});

  for (genvar k = 0; k < NBOUND; k++) begin : g_bound
    logic [PROD_W-1:0] rhs;
    assign rhs   = PROD_W'(tan_q8(k)) * PROD_W'(ax);
    assign ge[k] = lhs >= rhs;
    assign gt[k] = lhs > rhs;
  end

  assign bin = fx[PIX_W] ? BNW'(NBINS - 1 - $countones(gt)) : BNW'($countones(ge));
endmodule

// File: rtl/hog_cellacc.sv
`timescale 1ns/1ps
module hog_cellacc
  import hog_pkg::*;
#(
  parameter int NCX   = 80,
  parameter int CXW   = 7,
  parameter int CYW   = 6,
  parameter int MAG_W = 9,
  parameter int BIN_W = 16,
  localparam int BNW = $clog2(NBINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic                   first,
  input  logic                   emit,
  input  logic [CXW-1:0]         cx,
  input  logic [CYW-1:0]         cy,
  input  logic [BNW-1:0]         bin,
  input  logic [MAG_W-1:0]       mag,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [CXW-1:0]         out_cell_x,
  output logic [CYW-1:0]         out_cell_y,
  output logic [NBINS*BIN_W-1:0] out_bins
);
  logic           load, vld_d, vld_q;
  logic [CXW-1:0] cx_q;
  logic [CYW-1:0] cy_q;

  assign load = step && emit;

  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    logic [BIN_W-1:0] col [NCX];
    logic [BIN_W:0]   base, add, sum;
    logic [BIN_W-1:0] sat, rec_q;
    assign base = first ? '0 : {1'b0, col[cx]};
    assign add  = (int'(bin) == k) ? (BIN_W+1)'(mag) : '0;
    assign sum  = base + add;
    assign sat  = sum[BIN_W] ? '1 : sum[BIN_W-1:0];
    always_ff @(posedge clk) begin
      if (step) col[cx] <= sat;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rec_q <= '0;
      else if (load) rec_q <= sat;
    end
    assign out_bins[k*BIN_W +: BIN_W] = rec_q;
  end

  always_comb begin
    vld_d = vld_q;
    if (out_ready) vld_d = 1'b0;
    if (load)      vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cx_q  <= '0;
      cy_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        cx_q <= cx;
        cy_q <= cy;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_cell_x = cx_q;
  assign out_cell_y = cy_q;
endmodule

// File: rtl/hog_cell_hist.sv
`timescale 1ns/1ps
module hog_cell_hist
  import hog_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int CELL  = 8,
  parameter int PIX_W = 8,
  parameter int BIN_W = 16,
  localparam int XW    = $clog2(IMG_W),
  localparam int YW    = $clog2(IMG_H),
  localparam int NCX   = IMG_W / CELL,
  localparam int NCY   = IMG_H / CELL,
  localparam int CXW   = (NCX > 1) ? $clog2(NCX) : 1,
  localparam int CYW   = (NCY > 1) ? $clog2(NCY) : 1,
  localparam int MAG_W = PIX_W + 1,
  localparam int BNW   = $clog2(NBINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_pix,
  input  logic                   in_sof,
  input  logic                   in_eol,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CXW-1:0]         out_cell_x,
  output logic [CYW-1:0]         out_cell_y,
  output logic [NBINS*BIN_W-1:0] out_bins
);
  localparam logic [XW-1:0] XLAST = XW'(IMG_W - 1);
  localparam logic [YW-1:0] YLAST = YW'(IMG_H - 1);

  logic [XW-1:0] in_x_q, in_x_d, fx_q, fx_d, px, proc_x;
  logic [YW-1:0] in_y_q, in_y_d, py, proc_r;
  logic          sel_q, sel_d, drain_q, drain_d;
  logic          out_free, accept, step, first, emit;
  logic [PIX_W-1:0] c_l, c_r, c_m, o_m, up, down;
  logic [MAG_W-1:0] mag;
  logic [BNW-1:0]   bin;

  assign out_free = !out_valid || out_ready;
  assign in_ready = out_free && !drain_q;
  assign accept   = in_valid && in_ready;
  assign px       = in_sof ? '0 : in_x_q;
  assign py       = in_sof ? '0 : in_y_q;
  assign proc_x   = drain_q ? fx_q : px;
  assign proc_r   = drain_q ? YLAST : py - 1'b1;
  assign step     = drain_q ? out_free : (accept && py != '0);
  assign first    = (int'(proc_r) % CELL == 0) && (int'(proc_x) % CELL == 0);
  assign emit     = (int'(proc_r) % CELL == CELL - 1) && (int'(proc_x) % CELL == CELL - 1);
  assign up       = (!drain_q && py == YW'(1)) ? c_m : o_m;
  assign down     = drain_q ? c_m : in_pix;

  // position and drain control: next state
  always_comb begin
    in_x_d  = in_x_q;
    in_y_d  = in_y_q;
    sel_d   = sel_q;
    drain_d = drain_q;
    fx_d    = fx_q;
    if (accept) begin
      in_x_d = px + 1'b1;
      in_y_d = py;
      if (in_eol) begin
        in_x_d = '0;
        sel_d  = ~sel_q;
        if (py == YLAST) begin
          in_y_d  = '0;
          drain_d = 1'b1;
          fx_d    = '0;
        end else begin
          in_y_d = py + 1'b1;
        end
      end
    end
    if (drain_q && out_free) begin
      if (fx_q == XLAST) drain_d = 1'b0;
      else               fx_d    = fx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_x_q  <= '0;
      in_y_q  <= '0;
      sel_q   <= 1'b0;
      drain_q <= 1'b0;
      fx_q    <= '0;
    end else begin
      in_x_q  <= in_x_d;
      in_y_q  <= in_y_d;
      sel_q   <= sel_d;
      drain_q <= drain_d;
      fx_q    <= fx_d;
    end
  end

  hog_linebuf #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_lb (
    .clk(clk), .wr_en(accept), .cur_sel(sel_q), .pos_x(proc_x), .wr_pix(in_pix),
    .cur_left(c_l), .cur_right(c_r), .cur_mid(c_m), .oth_mid(o_m)
  );

  hog_gradbin #(.PIX_W(PIX_W)) u_gb (
    .left(c_l), .right(c_r), .up(up), .down(down), .mag(mag), .bin(bin)
  );

  hog_cellacc #(.NCX(NCX), .CXW(CXW), .CYW(CYW), .MAG_W(MAG_W), .BIN_W(BIN_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(step), .first(first), .emit(emit),
    .cx(CXW'(int'(proc_x) / CELL)), .cy(CYW'(int'(proc_r) / CELL)),
    .bin(bin), .mag(mag), .out_ready(out_ready), .out_valid(out_valid),
    .out_cell_x(out_cell_x), .out_cell_y(out_cell_y), .out_bins(out_bins)
  );
endmodule

// File: rtl/hog_cell_hist_chk.sv
`timescale 1ns/1ps
module hog_cell_hist_chk
  import hog_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int CELL  = 8,
  parameter int BIN_W = 16,
  localparam int NCX = IMG_W / CELL,
  localparam int NCY = IMG_H / CELL,
  localparam int CXW = (NCX > 1) ? $clog2(NCX) : 1,
  localparam int CYW = (NCY > 1) ? $clog2(NCY) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_sof,
  input logic                   in_eol,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [CXW-1:0]         out_cell_x,
  input logic [CYW-1:0]         out_cell_y,
  input logic [NBINS*BIN_W-1:0] out_bins
);
  int   line_q, ecx_q, ecy_q, line_eff;
  logic last_line_q;

  assign line_eff = in_sof ? 0 : line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= 0;
      last_line_q <= 1'b0;
      ecx_q       <= 0;
      ecy_q       <= 0;
    end else begin
      last_line_q <= in_valid && in_ready && in_eol && (line_eff == IMG_H - 1);
      if (in_valid && in_ready) begin
        if (in_eol) line_q <= (line_eff == IMG_H - 1) ? 0 : line_eff + 1;
        else        line_q <= line_eff;
      end
      if (out_valid && out_ready) begin
        if (ecx_q == NCX - 1) begin
          ecx_q <= 0;
          ecy_q <= (ecy_q == NCY - 1) ? 0 : ecy_q + 1;
        end else begin
          ecx_q <= ecx_q + 1;
        end
      end
    end
  end

  AST_RASTER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> int'(out_cell_x) == ecx_q && int'(out_cell_y) == ecy_q); // R6
  AST_DRAIN_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    last_line_q |-> !in_ready); // R6
  AST_CELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_cell_x) < NCX && int'(out_cell_y) < NCY); // R5
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bins) && $stable(out_cell_x) && $stable(out_cell_y)); // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
endmodule

bind hog_cell_hist hog_cell_hist_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .CELL(CELL), .BIN_W(BIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
  .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
  .out_cell_x(out_cell_x), .out_cell_y(out_cell_y), .out_bins(out_bins)
);

// File: tb/hog_cell_hist_tb.sv
`timescale 1ns/1ps
module hog_cell_hist_tb;
  localparam int W = 32, H = 16, CL = 8, BW = 12, NB = 9;
  localparam int NCX = W / CL, NCY = H / CL;
  localparam int SATV = (1 << BW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [7:0] in_pix = '0;
  logic in_ready, out_valid;
  logic [1:0] out_cell_x;
  logic [0:0] out_cell_y;
  logic [NB*BW-1:0] out_bins;

  int n_chk = 0, n_fail = 0, bp_mode = 0;
  bit done = 0;
  int img [H][W];
  int q_cx[$], q_cy[$], q_bin[$];
  string q_tag[$];

  always #10 clk = ~clk;

  hog_cell_hist #(.IMG_W(W), .IMG_H(H), .CELL(CL), .PIX_W(8), .BIN_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_cell_x(out_cell_x), .out_cell_y(out_cell_y), .out_bins(out_bins)
  );

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int bin_of(input int gx_i, input int gy_i);
    int gx = gx_i, gy = gy_i, a, c = 0;
    int tq [4] = '{93, 215, 443, 1452};
    if (gy < 0 || (gy == 0 && gx < 0)) begin gx = -gx; gy = -gy; end
    a = (gx < 0) ? -gx : gx;
    for (int k = 0; k < 4; k++)
      if (gx >= 0 ? (gy * 256 >= tq[k] * a) : (gy * 256 > tq[k] * a)) c++;
    return (gx >= 0) ? c : 8 - c;
  endfunction

  task automatic push_expect(input string tag);
    for (int cy = 0; cy < NCY; cy++)
      for (int cx = 0; cx < NCX; cx++) begin
        int b [NB];
        for (int k = 0; k < NB; k++) b[k] = 0;
        for (int y = cy*CL; y < cy*CL + CL; y++)
          for (int x = cx*CL; x < cx*CL + CL; x++) begin
            int gx = img[y][clampi(x+1, 0, W-1)] - img[y][clampi(x-1, 0, W-1)];
            int gy = img[clampi(y+1, 0, H-1)][x] - img[clampi(y-1, 0, H-1)][x];
            b[bin_of(gx, gy)] += ((gx < 0) ? -gx : gx) + ((gy < 0) ? -gy : gy);
          end
        q_cx.push_back(cx); q_cy.push_back(cy); q_tag.push_back(tag);
        for (int k = 0; k < NB; k++) q_bin.push_back((b[k] > SATV) ? SATV : b[k]);
      end
  endtask

  task automatic drive_pix(input int p, input logic s, input logic e);
    in_pix = 8'(p); in_sof = s; in_eol = e; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic send_frame(input string tag, input bit gaps, input int junk);
    push_expect(tag);
    for (int j = 0; j < junk; j++) drive_pix(int'($urandom % 256), 1'b0, 1'b0);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (gaps) repeat ($urandom % 2) @(negedge clk);
        drive_pix(img[y][x], (x == 0 && y == 0), (x == W-1));
      end
    while (q_cx.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rec();
    int ecx, ecy, bad = -1, act = 0, exp_v = 0;
    string tag;
    n_chk++;
    if (q_cx.size() == 0) begin
      n_fail++;
      $display("FAIL R6 unexpected record: actual cell=(%0d,%0d) expected=none", out_cell_x, out_cell_y);
      return;
    end
    ecx = q_cx.pop_front(); ecy = q_cy.pop_front(); tag = q_tag.pop_front();
    for (int k = 0; k < NB; k++) begin
      int e = q_bin.pop_front();
      int a = int'(out_bins[k*BW +: BW]);
      if (a != e && bad < 0) begin bad = k; act = a; exp_v = e; end
    end
    if (int'(out_cell_x) != ecx || int'(out_cell_y) != ecy) begin
      n_fail++;
      $display("FAIL %s R6 cell order: actual=(%0d,%0d) expected=(%0d,%0d)", tag, out_cell_x, out_cell_y, ecx, ecy);
    end else if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s R5 cell (%0d,%0d) bin %0d: actual=%0d expected=%0d", tag, ecx, ecy, bad, act, exp_v);
    end
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      out_ready = (bp_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (out_valid && out_ready) check_rec();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    n_chk++; if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1 out_valid: actual=%b expected=0", out_valid); end
    n_chk++; if (in_ready !== 1'b1) begin n_fail++; $display("FAIL R1 in_ready: actual=%b expected=1", in_ready); end

    // R2 R3: horizontal ramp, only gx
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = x * 7;
    send_frame("R2 R3", 1'b0, 0);
    // R2 R8: vertical ramp with output stalls
    bp_mode = 1;
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 255 - y * 13;
    send_frame("R2 R8", 1'b0, 0);
    // R4 R8: random texture, input gaps and stalls
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = int'($urandom % 256);
    send_frame("R4 R8", 1'b1, 0);
    // R4: curved surface covers many orientations
    bp_mode = 0;
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = (x*x + 3*y*y + 5*x*y) % 256;
    send_frame("R4", 1'b0, 0);
    // R7: two-column stripes saturate the bins
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = ((x / 2) % 2) ? 255 : 0;
    send_frame("R7", 1'b0, 0);
    // R9: stray pixels before start of frame
    bp_mode = 1;
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = int'($urandom % 256);
    send_frame("R9", 1'b1, 5);
    // R3: flat frame gives zero bins
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 77;
    send_frame("R3", 1'b0, 0);

    n_chk++;
    if (q_cx.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing records: actual=%0d left expected=0", q_cx.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule